// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects the completion and fault interrupts of an eight-channel DMA engine and presents them to software. Each channel owns two sticky flags, one set by a one-cycle terminal-count pulse and one by a one-cycle error pulse. The block does not store interrupt masks of its own. Instead it reads the enable bits straight out of each channel's 32-bit configuration word, which the surrounding controller supplies on a flat input bus.

Software sees the flags through a word-addressed register port. The reads are combinational. It can view the flags raw, view them masked per type, or view the combined masked set. It can also list the channels whose enable bit is set. A flag is cleared by writing a one to its position in the clear register for its type. A single registered interrupt line goes high whenever any masked flag is pending.

Top module: `dma_irq_unit`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), every raw flag is zero and `irq` is low.
- R2: A high bit in `tc_evt` or `err_evt` during a clock edge sets the matching raw flag. Raw completion flags read at word address 5 and raw fault flags read at word address 6, with channel c on data bit c. A raw flag is never set without an event.
- R3: The completion mask of channel c is bit 15 of its configuration word and the fault mask is bit 14. Address 1 reads raw completion flags ANDed with their masks, and address 3 reads raw fault flags ANDed with their masks.
- R4: Address 0 reads the bitwise OR of the two masked views.
- R5: A write to address 2 clears every raw completion flag whose bit in `reg_wdata` is 1 and leaves the others unchanged. A write to address 4 does the same for the raw fault flags.
- R6: When an event and a clear hit the same flag at the same clock edge, the flag ends up set.
- R7: Address 7 reads, on bit c, bit 0 (the enable bit) of channel c's configuration word.
- R8: `irq` is registered. After each clock edge it equals the OR of all masked flags as they stood before that edge.
- R9: Reads of any address other than 0, 1, 3, 5, 6 and 7 return zero. Writes to addresses other than 2 and 4 change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tc_evt | input | 8 | Per-channel terminal-count pulses |
| err_evt | input | 8 | Per-channel error pulses |
| chan_cfg | input | 256 | Configuration words; channel c occupies bits 32c+31 down to 32c |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a completion pulse and a clear write that target the same flag at the same clock edge. The directed task raises the event and the write strobe together on one falling edge, so both land at the next rising edge. It then reads the raw view to confirm the flag survived. The mask path is tested by changing only the configuration input while the raw flags stay fixed. Any change in the masked views or in `irq` must then come from the configuration bits alone.

// File: rtl/dma_irq_unit.sv
module dma_irq_unit #(
  parameter int NCH = 8,
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int CFG_W = 32,
  parameter int TC_MASK_BIT = 15,
  parameter int ERR_MASK_BIT = 14,
  parameter int EN_BIT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       tc_evt,
  input  logic [NCH-1:0]       err_evt,
  input  logic [NCH*CFG_W-1:0] chan_cfg,
  input  logic [AW-1:0]        reg_addr,
  input  logic                 reg_wr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic                 irq
);
  localparam logic [AW-1:0] A_ANY    = AW'(0);
  localparam logic [AW-1:0] A_TC     = AW'(1);
  localparam logic [AW-1:0] A_TC_CLR = AW'(2);
  localparam logic [AW-1:0] A_ERR    = AW'(3);
  localparam logic [AW-1:0] A_ERR_CLR= AW'(4);
  localparam logic [AW-1:0] A_TC_RAW = AW'(5);
  localparam logic [AW-1:0] A_ERR_RAW= AW'(6);
  localparam logic [AW-1:0] A_EN     = AW'(7);
  localparam int PAD = DW - NCH;

  logic [NCH-1:0] tc_raw, err_raw, tc_mask, err_mask, ch_en;
  logic [NCH-1:0] tc_clr, err_clr, tc_vis, err_vis, sel;

  for (genvar c = 0; c < NCH; c++) begin : g_cfg
    assign tc_mask[c]  = chan_cfg[c*CFG_W + TC_MASK_BIT];
    assign err_mask[c] = chan_cfg[c*CFG_W + ERR_MASK_BIT];
    assign ch_en[c]    = chan_cfg[c*CFG_W + EN_BIT];
  end

  assign tc_clr  = (reg_wr && reg_addr == A_TC_CLR)  ? reg_wdata[NCH-1:0] : '0;
  assign err_clr = (reg_wr && reg_addr == A_ERR_CLR) ? reg_wdata[NCH-1:0] : '0;
  assign tc_vis  = tc_raw & tc_mask;
  assign err_vis = err_raw & err_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_raw  <= '0;
      err_raw <= '0;
      irq     <= 1'b0;
    end else begin
      tc_raw  <= (tc_raw & ~tc_clr) | tc_evt;
      err_raw <= (err_raw & ~err_clr) | err_evt;
      irq     <= |(tc_vis | err_vis);
    end
  end

  always_comb begin
    case (reg_addr)
      A_ANY:     sel = tc_vis | err_vis;
      A_TC:      sel = tc_vis;
      A_ERR:     sel = err_vis;
      A_TC_RAW:  sel = tc_raw;
      A_ERR_RAW: sel = err_raw;
      A_EN:      sel = ch_en;
      default:   sel = '0;
    endcase
  end

  assign reg_rdata = {{PAD{1'b0}}, sel};
endmodule

module dma_irq_unit_chk #(
  parameter int NCH = 8,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] tc_evt,
  input logic [NCH-1:0] err_evt,
  input logic [AW-1:0]  reg_addr,
  input logic           reg_wr,
  input logic [DW-1:0]  reg_wdata,
  input logic [NCH-1:0] tc_raw,
  input logic [NCH-1:0] err_raw,
  input logic [NCH-1:0] tc_mask,
  input logic [NCH-1:0] err_mask,
  input logic           irq
);
  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (tc_raw == '0 && err_raw == '0 && !irq));

  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    (|tc_evt) |=> ((tc_raw & $past(tc_evt)) == $past(tc_evt)));

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    ##1 ((tc_raw & ~$past(tc_raw)) & ~$past(tc_evt)) == '0);

  a_r5_tc_cleared: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == AW'(2)) |=>
      ((tc_raw & $past(reg_wdata[NCH-1:0] & ~tc_evt)) == '0));

  a_r5_err_cleared: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == AW'(4)) |=>
      ((err_raw & $past(reg_wdata[NCH-1:0] & ~err_evt)) == '0));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == AW'(2) && (|tc_evt)) |=>
      ((tc_raw & $past(tc_evt)) == $past(tc_evt)));

  a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
    ##1 irq |-> $past(|((tc_raw & tc_mask) | (err_raw & err_mask))));
endmodule

bind dma_irq_unit dma_irq_unit_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .tc_evt(tc_evt), .err_evt(err_evt),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .tc_raw(tc_raw), .err_raw(err_raw), .tc_mask(tc_mask),
  .err_mask(err_mask), .irq(irq)
);

// File: tb/test_dma_irq_unit.sv
module test_dma_irq_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   tc_evt = '0, err_evt = '0;
  logic [255:0] chan_cfg = '0;
  logic [3:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_irq_unit i_dma_irq_unit (
    .clk(clk), .rst(rst), .tc_evt(tc_evt), .err_evt(err_evt),
    .chan_cfg(chan_cfg), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(logic [7:0] t, logic [7:0] e);
    @(negedge clk);
    tc_evt = t; err_evt = e;
    @(negedge clk);
    tc_evt = '0; err_evt = '0;
  endtask

  task automatic set_cfg(int c, logic [31:0] w);
    chan_cfg[c*32 +: 32] = w;
  endtask

  task automatic t_reset();
    rd("R1 raw tc", 4'd5, 32'h0);
    rd("R1 raw err", 4'd6, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_raw_set();
    pulse(8'h05, 8'h80);
    rd("R2 raw tc", 4'd5, 32'h05);
    rd("R2 raw err", 4'd6, 32'h80);
    rd("R3 masked tc off", 4'd1, 32'h0);
    rd("R3 masked err off", 4'd3, 32'h0);
    rd("R4 any off", 4'd0, 32'h0);
    check("R8 irq low unmasked", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask();
    @(negedge clk);
    set_cfg(0, 32'h0000_8000);
    set_cfg(7, 32'h0000_4000);
    rd("R3 masked tc", 4'd1, 32'h01);
    rd("R3 masked err", 4'd3, 32'h80);
    rd("R4 any", 4'd0, 32'h81);
    @(negedge clk);
    check("R8 irq high", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_clear();
    wr(4'd5, 32'hFF);
    rd("R9 write to raw view ignored", 4'd5, 32'h05);
    wr(4'd2, 32'h04);
    rd("R5 tc partial clear", 4'd5, 32'h01);
    wr(4'd4, 32'hFF);
    rd("R5 err clear", 4'd6, 32'h00);
    wr(4'd2, 32'h01);
    rd("R5 tc clear", 4'd5, 32'h00);
    @(negedge clk);
    check("R8 irq low after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    tc_evt = 8'h02; reg_addr = 4'd2; reg_wdata = 32'h02; reg_wr = 1'b1;
    @(negedge clk);
    tc_evt = '0; reg_wr = 1'b0;
    rd("R6 set beats clear", 4'd5, 32'h02);
    wr(4'd2, 32'h02);
    rd("R6 later clear works", 4'd5, 32'h00);
  endtask

  task automatic t_enable();
    @(negedge clk);
    chan_cfg = '0;
    set_cfg(1, 32'h1);
    set_cfg(3, 32'h0000_C001);
    set_cfg(6, 32'hFFFF_FFFF);
    rd("R7 enabled channels", 4'd7, 32'h4A);
  endtask

  task automatic t_undecoded();
    pulse(8'hFF, 8'hFF);
    rd("R9 addr 2 read", 4'd2, 32'h0);
    rd("R9 addr 4 read", 4'd4, 32'h0);
    rd("R9 addr 8 read", 4'd8, 32'h0);
    rd("R9 addr 15 read", 4'd15, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_raw_set();
    t_mask();
    t_clear();
    t_set_wins();
    t_enable();
    t_undecoded();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule